// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-visible control and status store of a DMA engine with up to 64 channels. A simple word-addressed register bus writes and reads it. It keeps four per-channel bitmaps: request enable, error-interrupt enable, interrupt pending and error pending. Each bitmap is reachable as two 32-bit words, one for channels 63..32 and one for channels 31..0. It also holds a global control word, a per-channel priority byte and an error status word that captures the first reported error.

Two command words let software change a single channel without a read-modify-write. Each byte lane of a command word is its own command. The value written into a lane is a channel number, and the command acts on that channel only. A second command word clears one channel's interrupt or error flag, or sends a one-cycle start or clear-done pulse to the transfer engine. The transfer engine feeds in interrupt and error events and error reports. The block drives the request enables, the start and clear-done pulses, the control bits, the priorities and a single interrupt line.

Top module: `dma_ctl_regfile`

## Requirements
- R1: After reset every stored word reads zero, and every output is low: irq_o, req_en_o, start_o, done_clr_o and the control bits.
- R2: The control word (byte 0x00) keeps only bit 31 (clock gating enable), bit 3 (round-robin group arbitration) and bit 2 (round-robin channel arbitration). These drive clk_gate_en_o, rr_group_o and rr_chan_o. All other bits read 0.
- R3: The request-enable words are read/write: bytes 0x08 (channels 63..32, bit n-32) and 0x0C (channels 31..0, bit n). The error-interrupt-enable words use the same layout at 0x10 and 0x14. req_en_o[n] is channel n's request-enable bit and changes only on a bus write.
- R4: Byte lane k of a write carries wdata[8k+7:8k] and is valid when be[k] is set. In the command word at 0x18, lane 0 sets and lane 1 clears one request-enable bit, lane 2 sets and lane 3 clears one error-interrupt-enable bit. The channel is the byte value, and no other channel changes.
- R5: A command byte whose value is 64 or above (or at least the channel count) has no effect.
- R6: An int_evt[n] or err_evt[n] pulse sets the interrupt bit (words 0x20/0x24) or the error bit (words 0x28/0x2C) of channel n. Writing ones to these words clears the matching bits, and writing all ones clears every channel. An event in the same cycle as a clear leaves the bit set.
- R7: In the command word at 0x1C, lane 0 clears one channel's interrupt bit and lane 1 clears one channel's error bit.
- R8: In the command word at 0x1C, lane 2 drives start_o and lane 3 drives done_clr_o. Each output carries a one-hot pulse for the named channel in the cycle after the write, and is zero otherwise.
- R9: irq_o is high exactly when any interrupt bit is set, or any error bit is set whose error-interrupt enable is set.
- R10: The error status word (0x04) captures the first error report, as {valid bit 31, group priority bit 15, channel priority bit 14, channel bits 13:8, causes bits 7:0}, where err_kind[9:8] feed bits 15:14 and err_kind[7:0] feed bits 7:0. While it is valid, later reports leave it unchanged.
- R11: A write to 0x04 with be[3] set and wdata[31] set clears the error status. A write without bit 31 does not. A report in the same cycle as the clear is captured.
- R12: Channel n's priority byte sits at byte 0x100+n (word 0x100+4*(n/4), lane n%4). It is read/write with byte enables and drives prio_o[8n+7:8n].
- R13: Read data appears on bus_rdata the cycle after bus_rd and holds until the next read. Command words and unmapped words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_waddr | input | 7 | Word address (byte address / 4) |
| bus_be | input | 4 | Byte enables, lane k = wdata[8k+7:8k] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| int_evt | input | NCH | Per-channel interrupt event pulses |
| err_evt | input | NCH | Per-channel error event pulses |
| err_rpt_valid | input | 1 | Error report strobe |
| err_rpt_chan | input | 6 | Channel of the reported error |
| err_rpt_kind | input | 10 | Error causes: [9] group priority, [8] channel priority, [7:0] status bits 7:0 |
| req_en_o | output | NCH | Per-channel request enables |
| start_o | output | NCH | One-cycle start pulses |
| done_clr_o | output | NCH | One-cycle clear-done pulses |
| clk_gate_en_o | output | 1 | Dynamic clock gating enable |
| rr_group_o | output | 1 | Round-robin group arbitration enable |
| rr_chan_o | output | 1 | Round-robin channel arbitration enable |
| prio_o | output | 8*NCH | Per-channel priority bytes |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench targets the edges of index decoding. It uses channels 0, 33, 40 and 63 and command bytes 64 and up. A decoder that wraps or truncates the index would change a wrong channel or act on an out-of-range byte. It races an engine event against a write-ones clear or a clear command in the same cycle. If the clear won, the event would be lost. It sends a second error report while the status is valid and a report in the clear cycle. A design that overwrote the status, or dropped the new report, would read back the wrong channel or zero. It checks that an error with its interrupt disabled keeps irq_o low. It also checks that the start pulse lasts exactly one cycle.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  // Word indices (byte offset / 4)
  localparam logic [6:0] W_CTRL   = 7'h00;  // 0x00
  localparam logic [6:0] W_ESTAT  = 7'h01;  // 0x04
  localparam logic [6:0] W_REQ_HI = 7'h02;  // 0x08
  localparam logic [6:0] W_REQ_LO = 7'h03;  // 0x0C
  localparam logic [6:0] W_EEI_HI = 7'h04;  // 0x10
  localparam logic [6:0] W_EEI_LO = 7'h05;  // 0x14
  localparam logic [6:0] W_CMD_EN = 7'h06;  // 0x18 enable set/clear commands
  localparam logic [6:0] W_CMD_ST = 7'h07;  // 0x1C status/pulse commands
  localparam logic [6:0] W_INT_HI = 7'h08;  // 0x20
  localparam logic [6:0] W_INT_LO = 7'h09;  // 0x24
  localparam logic [6:0] W_ERR_HI = 7'h0A;  // 0x28
  localparam logic [6:0] W_ERR_LO = 7'h0B;  // 0x2C
  localparam logic [6:0] W_PRIO   = 7'h40;  // 0x100

  localparam int unsigned MAXCH  = 64;
  localparam int unsigned PRIO_W = 8;
  localparam logic [31:0] CTRL_KEEP = 32'h8000_000C;

  typedef struct packed {
    logic       valid;
    logic       grp_prio;
    logic       chn_prio;
    logic [5:0] chan;
    logic [7:0] cause;
  } estat_t;

  function automatic logic [31:0] estat_word(input estat_t s);
    return {s.valid, 15'b0, s.grp_prio, s.chn_prio, s.chan, s.cause};
  endfunction
endpackage

// File: rtl/dma_ctl_rst_sync.sv
module dma_ctl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dma_ctl_cmd_dec.sv
module dma_ctl_cmd_dec #(
  parameter int NCH = 64
) (
  input  logic        en,
  input  logic [7:0]  idx,
  output logic [63:0] hit
);
  for (genvar c = 0; c < 64; c++) begin : g_hit
    if (c < NCH) begin : g_live
      assign hit[c] = en && (idx == 8'(c));
    end else begin : g_dead
      assign hit[c] = 1'b0;
    end
  end
endmodule

// File: rtl/dma_ctl_bitmap.sv
module dma_ctl_bitmap #(
  parameter int NCH = 64,
  parameter bit W1C = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hi,
  input  logic        wr_lo,
  input  logic [31:0] wdata,
  input  logic [31:0] wmask,
  input  logic [63:0] set,
  input  logic [63:0] clr,
  output logic [63:0] bits
);
  localparam logic [63:0] LIVE = (NCH >= 64) ? {64{1'b1}} : ((64'd1 << NCH) - 64'd1);

  logic [63:0] q, d, m64, w64, after_wr;
  logic        upd;

  assign m64 = {wr_hi ? wmask : 32'h0, wr_lo ? wmask : 32'h0};
  assign w64 = {wdata, wdata} & m64;

  if (W1C) begin : g_w1c
    assign after_wr = q & ~w64;
  end else begin : g_rw
    assign after_wr = (q & ~m64) | w64;
  end

  always_comb begin
    d   = ((after_wr & ~clr) | set) & LIVE;
    upd = (|m64) || (|set) || (|clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= d;
  end

  assign bits = q;
endmodule

// File: rtl/dma_ctl_err_cap.sv
module dma_ctl_err_cap
  import dma_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        rpt_valid,
  input  logic [5:0]  rpt_chan,
  input  logic [9:0]  rpt_kind,
  output logic [31:0] status
);
  estat_t q, d;
  logic   upd;

  always_comb begin
    d = clr ? '0 : q;
    if (rpt_valid && !d.valid) begin
      d.valid    = 1'b1;
      d.grp_prio = rpt_kind[9];
      d.chn_prio = rpt_kind[8];
      d.chan     = rpt_chan;
      d.cause    = rpt_kind[7:0];
    end
    upd = clr || rpt_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= d;
  end

  assign status = estat_word(q);
endmodule

// File: rtl/dma_ctl_regfile.sv
module dma_ctl_regfile
  import dma_ctl_pkg::*;
#(
  parameter int NCH = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [6:0]            bus_waddr,
  input  logic [3:0]            bus_be,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NCH-1:0]        int_evt,
  input  logic [NCH-1:0]        err_evt,
  input  logic                  err_rpt_valid,
  input  logic [5:0]            err_rpt_chan,
  input  logic [9:0]            err_rpt_kind,
  output logic [NCH-1:0]        req_en_o,
  output logic [NCH-1:0]        start_o,
  output logic [NCH-1:0]        done_clr_o,
  output logic                  clk_gate_en_o,
  output logic                  rr_group_o,
  output logic                  rr_chan_o,
  output logic [PRIO_W*NCH-1:0] prio_o,
  output logic                  irq_o
);
  localparam int NLANE = 4;

  logic        srst_n;
  logic [31:0] wmask, ctrl_q, ctrl_d, estat, rd_d, rd_prio, rdata_q;
  logic [63:0] hit_en [NLANE];
  logic [63:0] hit_st [NLANE];
  logic [63:0] req_q, eei_q, int_q, err_q, start_q, done_q;
  logic [63:0] int_evt_w, err_evt_w;
  logic        wr_cmd_en, wr_cmd_st, ctrl_we, estat_clr;
  logic [PRIO_W-1:0] prio_q [NCH];

  dma_ctl_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign wmask     = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
  assign wr_cmd_en = bus_wr && (bus_waddr == W_CMD_EN);
  assign wr_cmd_st = bus_wr && (bus_waddr == W_CMD_ST);
  assign int_evt_w = 64'(int_evt);
  assign err_evt_w = 64'(err_evt);

  // One index decoder per command lane
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    dma_ctl_cmd_dec #(.NCH(NCH)) u_en (
      .en(wr_cmd_en && bus_be[k]), .idx(bus_wdata[8*k +: 8]), .hit(hit_en[k]));
    dma_ctl_cmd_dec #(.NCH(NCH)) u_st (
      .en(wr_cmd_st && bus_be[k]), .idx(bus_wdata[8*k +: 8]), .hit(hit_st[k]));
  end

  dma_ctl_bitmap #(.NCH(NCH), .W1C(1'b0)) u_req (
    .clk(clk), .rst_n(srst_n),
    .wr_hi(bus_wr && bus_waddr == W_REQ_HI), .wr_lo(bus_wr && bus_waddr == W_REQ_LO),
    .wdata(bus_wdata), .wmask(wmask), .set(hit_en[0]), .clr(hit_en[1]), .bits(req_q));

  dma_ctl_bitmap #(.NCH(NCH), .W1C(1'b0)) u_eei (
    .clk(clk), .rst_n(srst_n),
    .wr_hi(bus_wr && bus_waddr == W_EEI_HI), .wr_lo(bus_wr && bus_waddr == W_EEI_LO),
    .wdata(bus_wdata), .wmask(wmask), .set(hit_en[2]), .clr(hit_en[3]), .bits(eei_q));

  dma_ctl_bitmap #(.NCH(NCH), .W1C(1'b1)) u_int (
    .clk(clk), .rst_n(srst_n),
    .wr_hi(bus_wr && bus_waddr == W_INT_HI), .wr_lo(bus_wr && bus_waddr == W_INT_LO),
    .wdata(bus_wdata), .wmask(wmask), .set(int_evt_w), .clr(hit_st[0]), .bits(int_q));

  dma_ctl_bitmap #(.NCH(NCH), .W1C(1'b1)) u_err (
    .clk(clk), .rst_n(srst_n),
    .wr_hi(bus_wr && bus_waddr == W_ERR_HI), .wr_lo(bus_wr && bus_waddr == W_ERR_LO),
    .wdata(bus_wdata), .wmask(wmask), .set(err_evt_w), .clr(hit_st[1]), .bits(err_q));

  assign estat_clr = bus_wr && (bus_waddr == W_ESTAT) && bus_be[3] && bus_wdata[31];

  dma_ctl_err_cap u_ecap (
    .clk(clk), .rst_n(srst_n), .clr(estat_clr), .rpt_valid(err_rpt_valid),
    .rpt_chan(err_rpt_chan), .rpt_kind(err_rpt_kind), .status(estat));

  // Control word
  assign ctrl_we = bus_wr && (bus_waddr == W_CTRL);
  assign ctrl_d  = ((ctrl_q & ~wmask) | (bus_wdata & wmask)) & CTRL_KEEP;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  // Engine pulses, one cycle after the command write
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      start_q <= '0;
      done_q  <= '0;
    end else begin
      start_q <= hit_st[2];
      done_q  <= hit_st[3];
    end
  end

  // Priority bytes
  for (genvar c = 0; c < NCH; c++) begin : g_prio
    localparam int WI = c / 4;
    localparam int LN = c % 4;
    logic pw_en;
    assign pw_en = bus_wr && (bus_waddr == W_PRIO + 7'(WI)) && bus_be[LN];
    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)    prio_q[c] <= '0;
      else if (pw_en) prio_q[c] <= bus_wdata[8*LN +: 8];
    end
    assign prio_o[PRIO_W*c +: PRIO_W] = prio_q[c];
  end

  // Read path
  always_comb begin
    rd_prio = '0;
    for (int c = 0; c < NCH; c++) begin
      if (bus_waddr == W_PRIO + 7'(c / 4)) rd_prio[8*(c % 4) +: 8] = prio_q[c];
    end
    rd_d = '0;
    case (bus_waddr)
      W_CTRL:   rd_d = ctrl_q;
      W_ESTAT:  rd_d = estat;
      W_REQ_HI: rd_d = req_q[63:32];
      W_REQ_LO: rd_d = req_q[31:0];
      W_EEI_HI: rd_d = eei_q[63:32];
      W_EEI_LO: rd_d = eei_q[31:0];
      W_INT_HI: rd_d = int_q[63:32];
      W_INT_LO: rd_d = int_q[31:0];
      W_ERR_HI: rd_d = err_q[63:32];
      W_ERR_LO: rd_d = err_q[31:0];
      default:  rd_d = (bus_waddr >= W_PRIO) ? rd_prio : 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_d;
  end

  assign bus_rdata     = rdata_q;
  assign req_en_o      = req_q[NCH-1:0];
  assign start_o       = start_q[NCH-1:0];
  assign done_clr_o    = done_q[NCH-1:0];
  assign clk_gate_en_o = ctrl_q[31];
  assign rr_group_o    = ctrl_q[3];
  assign rr_chan_o     = ctrl_q[2];
  assign irq_o         = (|int_q) || (|(err_q & eei_q));
endmodule

// File: rtl/dma_ctl_regfile_chk.sv
module dma_ctl_regfile_chk
  import dma_ctl_pkg::*;
#(
  parameter int NCH = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [6:0]     bus_waddr,
  input logic [3:0]     bus_be,
  input logic [31:0]    bus_wdata,
  input logic [NCH-1:0] int_evt,
  input logic [NCH-1:0] req_en_o,
  input logic [NCH-1:0] start_o,
  input logic [NCH-1:0] done_clr_o,
  input logic           irq_o,
  input logic [NCH-1:0] int_bits,
  input logic [31:0]    estat
);
  logic bad_cmd_wr, estat_clr_wr;

  always_comb begin
    bad_cmd_wr = bus_wr && (bus_waddr == W_CMD_EN) && (|bus_be);
    for (int k = 0; k < 4; k++) begin
      if (bus_be[k] && (int'(bus_wdata[8*k +: 8]) < NCH)) bad_cmd_wr = 1'b0;
    end
    estat_clr_wr = bus_wr && (bus_waddr == W_ESTAT) && bus_be[3] && bus_wdata[31];
  end

  a_r8_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_o));

  a_r8_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_clr_o));

  a_r3_req_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(req_en_o));

  a_r5_bad_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd_wr |=> $stable(req_en_o));

  a_r6_event_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|int_evt) |=> ((int_bits & $past(int_evt)) == $past(int_evt)));

  a_r9_irq_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    (|int_evt) |=> irq_o);

  a_r10_first_error_held: assert property (@(posedge clk) disable iff (!rst_n)
    (estat[31] && !estat_clr_wr) |=> $stable(estat));
endmodule

bind dma_ctl_regfile dma_ctl_regfile_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(srst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .int_evt(int_evt),
  .req_en_o(req_en_o), .start_o(start_o), .done_clr_o(done_clr_o),
  .irq_o(irq_o), .int_bits(int_q[NCH-1:0]), .estat(estat));

// File: tb/dma_ctl_regfile_tb_top.sv
module dma_ctl_regfile_tb_top;
  localparam int NCH = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [6:0]        bus_waddr = '0;
  logic [3:0]        bus_be = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NCH-1:0]    int_evt = '0, err_evt = '0;
  logic              err_rpt_valid = 1'b0;
  logic [5:0]        err_rpt_chan = '0;
  logic [9:0]        err_rpt_kind = '0;
  logic [NCH-1:0]    req_en_o, start_o, done_clr_o;
  logic              clk_gate_en_o, rr_group_o, rr_chan_o, irq_o;
  logic [8*NCH-1:0]  prio_o;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_ctl_regfile #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_waddr(bus_waddr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .int_evt(int_evt), .err_evt(err_evt),
    .err_rpt_valid(err_rpt_valid), .err_rpt_chan(err_rpt_chan),
    .err_rpt_kind(err_rpt_kind), .req_en_o(req_en_o), .start_o(start_o),
    .done_clr_o(done_clr_o), .clk_gate_en_o(clk_gate_en_o),
    .rr_group_o(rr_group_o), .rr_chan_o(rr_chan_o), .prio_o(prio_o),
    .irq_o(irq_o));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Write: inputs driven at negedge, registers update at next posedge
  task automatic wr(input logic [11:0] addr, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = addr[8:2]; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [11:0] addr, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_waddr = addr[8:2];
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 64'(irq_o), 0);
    chk("R1 req_en", req_en_o, 0);
    chk("R1 pulses", start_o | done_clr_o, 0);
    chk("R1 ctrl outs", {61'b0, clk_gate_en_o, rr_group_o, rr_chan_o}, 0);
    rd(12'h000, d); chk("R1 ctrl word", 64'(d), 0);
    rd(12'h004, d); chk("R1 status word", 64'(d), 0);
    rd(12'h024, d); chk("R1 int word", 64'(d), 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(12'h000, 32'hFFFF_FFFF, 4'hF);
    rd(12'h000, d); chk("R2 ctrl keep bits", 64'(d), 64'h8000_000C);
    chk("R2 ctrl outs", {61'b0, clk_gate_en_o, rr_group_o, rr_chan_o}, 64'h7);
    wr(12'h000, 32'h0000_0004, 4'hF);
    rd(12'h000, d); chk("R2 ctrl rewrite", 64'(d), 64'h4);
    chk("R2 only rr_chan", {61'b0, clk_gate_en_o, rr_group_o, rr_chan_o}, 64'h1);
  endtask

  task automatic t_words_and_cmds();
    logic [31:0] d;
    wr(12'h00C, 32'hA5A5_A5A5, 4'hF);
    wr(12'h008, 32'h0000_00FF, 4'hF);
    chk("R3 req words", req_en_o, 64'h0000_00FF_A5A5_A5A5);
    rd(12'h008, d); chk("R3 req hi readback", 64'(d), 64'hFF);
    wr(12'h018, 32'h0000_0028, 4'h1);            // set ch40
    chk("R4 set ch40", req_en_o, 64'h0000_01FF_A5A5_A5A5);
    wr(12'h018, 32'h0000_0000, 4'h2);            // clear ch0
    chk("R4 clear ch0", req_en_o, 64'h0000_01FF_A5A5_A5A4);
    wr(12'h018, 32'h0000_003F, 4'h1);            // set ch63
    chk("R4 set ch63", req_en_o, 64'h8000_01FF_A5A5_A5A4);
    wr(12'h018, 32'h0000_3F00, 4'h2);            // clear ch63
    chk("R4 clear ch63", req_en_o, 64'h0000_01FF_A5A5_A5A4);
    wr(12'h018, 32'h0005_0000, 4'h4);            // set err-int enable ch5
    rd(12'h014, d); chk("R4 eei set ch5", 64'(d), 64'h20);
    wr(12'h018, 32'h4040_7FC8, 4'hF);            // all indices out of range
    chk("R5 req unchanged", req_en_o, 64'h0000_01FF_A5A5_A5A4);
    rd(12'h014, d); chk("R5 eei unchanged", 64'(d), 64'h20);
  endtask

  task automatic t_int_bits();
    logic [31:0] d;
    @(negedge clk); int_evt = '0; int_evt[3] = 1'b1; int_evt[50] = 1'b1;
    @(negedge clk); int_evt = '0;
    rd(12'h024, d); chk("R6 int lo", 64'(d), 64'h8);
    rd(12'h020, d); chk("R6 int hi", 64'(d), 64'h0004_0000);
    chk("R9 irq from int", 64'(irq_o), 1);
    wr(12'h024, 32'h0000_0008, 4'hF);
    rd(12'h024, d); chk("R6 w1c lo", 64'(d), 0);
    chk("R9 irq still high", 64'(irq_o), 1);
    wr(12'h020, 32'hFFFF_FFFF, 4'hF);
    rd(12'h020, d); chk("R6 w1c all hi", 64'(d), 0);
    chk("R9 irq low", 64'(irq_o), 0);
    @(negedge clk);                               // event races a clear-all
    bus_wr = 1'b1; bus_waddr = 7'h09; bus_wdata = 32'hFFFF_FFFF; bus_be = 4'hF;
    int_evt = '0; int_evt[7] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; int_evt = '0;
    rd(12'h024, d); chk("R6 event beats clear", 64'(d), 64'h80);
    wr(12'h01C, 32'h0000_0007, 4'h1);            // clear-interrupt ch7
    rd(12'h024, d); chk("R7 clear int ch7", 64'(d), 0);
    chk("R9 irq low after cmd", 64'(irq_o), 0);
  endtask

  task automatic t_err_bits();
    logic [31:0] d;
    @(negedge clk); err_evt = '0; err_evt[9] = 1'b1;
    @(negedge clk); err_evt = '0;
    rd(12'h02C, d); chk("R6 err lo", 64'(d), 64'h200);
    chk("R9 masked error", 64'(irq_o), 0);
    wr(12'h018, 32'h0009_0000, 4'h4);
    chk("R9 enabled error", 64'(irq_o), 1);
    wr(12'h01C, 32'h0000_0900, 4'h2);            // clear-error ch9
    rd(12'h02C, d); chk("R7 clear err ch9", 64'(d), 0);
    chk("R9 irq low", 64'(irq_o), 0);
    wr(12'h018, 32'h0900_0000, 4'h8);            // clear eei ch9
    rd(12'h014, d); chk("R4 eei clear ch9", 64'(d), 64'h20);
  endtask

  task automatic t_pulses();
    wr(12'h01C, 32'h0021_0000, 4'h4);
    chk("R8 start ch33", start_o, 64'd1 << 33);
    @(negedge clk);
    chk("R8 start one cycle", start_o, 0);
    wr(12'h01C, 32'h3F00_0000, 4'h8);
    chk("R8 done ch63", done_clr_o, 64'd1 << 63);
    chk("R8 no start", start_o, 0);
    @(negedge clk);
    chk("R8 done one cycle", done_clr_o, 0);
    wr(12'h01C, 32'h0040_0000, 4'h4);
    chk("R5 start index 64 ignored", start_o, 0);
  endtask

  task automatic report(input logic [5:0] ch, input logic [9:0] kind);
    @(negedge clk);
    err_rpt_valid = 1'b1; err_rpt_chan = ch; err_rpt_kind = kind;
    @(negedge clk);
    err_rpt_valid = 1'b0;
  endtask

  task automatic t_status();
    logic [31:0] d;
    report(6'd12, 10'h205);
    rd(12'h004, d); chk("R10 capture", 64'(d), 64'h8000_8C05);
    report(6'd20, 10'h3FF);
    rd(12'h004, d); chk("R10 first kept", 64'(d), 64'h8000_8C05);
    wr(12'h004, 32'h0000_0000, 4'hF);
    rd(12'h004, d); chk("R11 no clear without bit31", 64'(d), 64'h8000_8C05);
    wr(12'h004, 32'h8000_0000, 4'hF);
    rd(12'h004, d); chk("R11 cleared", 64'(d), 0);
    report(6'd1, 10'h080);
    @(negedge clk);                               // report races the clear
    bus_wr = 1'b1; bus_waddr = 7'h01; bus_wdata = 32'h8000_0000; bus_be = 4'hF;
    err_rpt_valid = 1'b1; err_rpt_chan = 6'd7; err_rpt_kind = 10'h001;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; err_rpt_valid = 1'b0;
    rd(12'h004, d); chk("R11 report in clear cycle", 64'(d), 64'h8000_0701);
  endtask

  task automatic t_prio_and_reads();
    logic [31:0] d;
    wr(12'h104, 32'h1122_3344, 4'hF);
    wr(12'h104, 32'h0000_AA00, 4'h2);
    rd(12'h104, d); chk("R12 prio word", 64'(d), 64'h1122_AA44);
    chk("R12 prio_o ch5", 64'(prio_o[8*5 +: 8]), 64'hAA);
    chk("R12 prio_o ch4", 64'(prio_o[8*4 +: 8]), 64'h44);
    wr(12'h13C, 32'h7E00_0000, 4'h8);
    chk("R12 prio_o ch63", 64'(prio_o[8*63 +: 8]), 64'h7E);
    rd(12'h040, d); chk("R13 unmapped reads zero", 64'(d), 0);
    rd(12'h018, d); chk("R13 command word reads zero", 64'(d), 0);
    rd(12'h13C, d);
    repeat (2) @(negedge clk);
    chk("R13 read data held", 64'(bus_rdata), 64'h7E00_0000);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctrl();
    t_words_and_cmds();
    t_int_bits();
    t_err_bits();
    t_pulses();
    t_status();
    t_prio_and_reads();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule